// File: doc/BRIEF.md
# Byte-Pair Register Controller

This block sits between a host byte link (a UART receiver and transmitter that already handle the bit-level framing) and the capture logic of a data-acquisition board. It reads the host's byte stream as a series of two-byte transactions. Each transaction is an address byte followed by a data byte. A write updates a small register file. A read makes the block return one byte holding the addressed register. Bytes enter and leave through a valid/ready handshake.

The register file drives three things. The first is a level-held software reset for the capture logic. The second is a mask that selects which internal data lanes feed the capture memory. The third is a first-edge polarity select, which is forced to rising whenever the two-lane double-data-rate mask is in force. A host that sends only one byte of a pair can desynchronise the link. To prevent this, a watchdog timer drops a pending address if its data byte does not arrive within a set number of cycles. The pairing logic and the register file are cleared only by the hardware reset pin, so the software reset they generate cannot disturb them.

Top module: `byte_pair_regctl`

## Requirements
- R1: The first byte accepted after an idle pairing state is taken as an address and the next accepted byte as its data. When address bit 7 is 0, the data is written to register address[6:0] and the new value is visible on the outputs in the cycle after the data byte is accepted.
- R2: Writing 0xFF to register 0x00 drives `sw_rst` high, and writing 0x00 to it drives `sw_rst` low. Any other value written to 0x00, and every other transaction, leaves `sw_rst` unchanged. A read of 0x00 returns 0xFF while `sw_rst` is high and 0x00 otherwise.
- R3: Register 0x02 holds the lane mask. Data bits [LANES-1:0] appear on `lane_en`, where bit n enables lane n. Upper data bits are dropped, and a read returns the mask zero-extended.
- R4: Bit 0 of register 0x13 selects the first edge: 0 means rising and 1 means falling. `edge_fall` equals this bit, except when `lane_en` is exactly 0b0011 (two-lane double-data-rate mode), in which case `edge_fall` is 0. A read of 0x13 returns the stored bit in bit 0.
- R5: An address byte with bit 7 set requests a read, and its data byte is ignored. One cycle after the data byte is accepted, `tx_valid` rises with `tx_data` equal to the register at address[6:0]. Both are held until the cycle in which `tx_ready` is high. A read changes no register.
- R6: `rx_ready` is low exactly while `tx_valid` is high, so no byte is consumed while a reply is pending.
- R7: After an address byte is accepted, a data byte is accepted only within the next TIMEOUT_CYC clock cycles. If none arrives, the address is discarded and the next accepted byte is again taken as an address.
- R8: Asserting `sw_rst` does not clear the lane mask, the edge bit or the pairing state.
- R9: A write to any address other than 0x00, 0x02 or 0x13 changes nothing, and a read of such an address returns 0x00.
- R10: While `rst_n` is low, `sw_rst`, `lane_en`, `edge_fall` and `tx_valid` are 0, `rx_ready` is 1, and the pairing state waits for an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| rx_data | input | BYTE_W | Byte received from the host |
| rx_valid | input | 1 | `rx_data` is valid |
| rx_ready | output | 1 | Block accepts `rx_data` this cycle |
| tx_data | output | BYTE_W | Read reply byte |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter takes `tx_data` this cycle |
| sw_rst | output | 1 | Level-held software reset to the capture logic |
| lane_en | output | LANES | Lane enable mask |
| edge_fall | output | 1 | Effective first-edge select (1 = falling) |

## Verification
Every write is visible on `sw_rst`, `lane_en` and `edge_fall` one clock edge after its data byte is accepted. A read reply appears on `tx_valid`/`tx_data` at that same edge, and `rx_ready` drops with it at once. The pairing watchdog gives up on the TIMEOUT_CYC-th edge after the address edge. The bench drives its inputs on the falling edge and updates a behavioural model on the rising edge. It compares all outputs on the next falling edge, so each result is sampled half a cycle after the edge that produced it. The directed checks wait out the same one-edge latency before they read a port.

// File: rtl/regctl_pkg.sv
package regctl_pkg;
   typedef enum logic {ST_ADDR = 1'b0, ST_DATA = 1'b1} pair_st_t;
   localparam logic [6:0] ADR_SWRST = 7'h00;
   localparam logic [6:0] ADR_LANE  = 7'h02;
   localparam logic [6:0] ADR_EDGE  = 7'h13;
endpackage

// File: rtl/pair_fsm.sv
module pair_fsm
   import regctl_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int TIMEOUT_CYC = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_fire,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              wr_en,
   output logic              rd_en,
   output logic [BYTE_W-1:0] addr_q,
   output logic              in_data
);
   localparam int TMR_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

   pair_st_t st;
   logic     expire;

   assign in_data = (st == ST_DATA);
   assign wr_en   = in_data && byte_fire && !addr_q[BYTE_W-1];
   assign rd_en   = in_data && byte_fire &&  addr_q[BYTE_W-1];

   generate
      if (TIMEOUT_CYC > 0) begin : g_tmr
         logic [TMR_W-1:0] tmr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  tmr <= '0;
            else if (!in_data)           tmr <= '0;
            else if (!byte_fire)         tmr <= tmr + 1'b1;
         end
         assign expire = in_data && !byte_fire && (tmr == TMR_W'(TIMEOUT_CYC - 1));
      end else begin : g_no_tmr
         assign expire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_ADDR;
         addr_q <= '0;
      end else begin
         case (st)
            ST_ADDR: if (byte_fire) begin
               addr_q <= byte_in;
               st     <= ST_DATA;
            end
            ST_DATA: if (byte_fire || expire) st <= ST_ADDR;
            default: st <= ST_ADDR;
         endcase
      end
   end
endmodule

// File: rtl/reg_bank.sv
module reg_bank
   import regctl_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-2:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   output logic              sw_rst,
   output logic [LANES-1:0]  lane_en,
   output logic              edge_sel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_rst   <= 1'b0;
         lane_en  <= '0;
         edge_sel <= 1'b0;
      end else if (wr_en) begin
         case (addr)
            ADR_SWRST: begin
               if (wdata == '1)      sw_rst <= 1'b1;
               else if (wdata == '0) sw_rst <= 1'b0;
            end
            ADR_LANE:  lane_en  <= wdata[LANES-1:0];
            ADR_EDGE:  edge_sel <= wdata[0];
            default:   ;
         endcase
      end
   end

   always_comb begin
      case (addr)
         ADR_SWRST: rdata = {BYTE_W{sw_rst}};
         ADR_LANE:  rdata = BYTE_W'(lane_en);
         ADR_EDGE:  rdata = BYTE_W'(edge_sel);
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/resp_buf.sv
module resp_buf #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_data,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [BYTE_W-1:0] tx_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else if (load) begin
         tx_valid <= 1'b1;
         tx_data  <= load_data;
      end else if (tx_valid && tx_ready) begin
         tx_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/byte_pair_regctl.sv
module byte_pair_regctl #(
   parameter int BYTE_W      = 8,
   parameter int LANES       = 4,
   parameter int TIMEOUT_CYC = 1024
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] rx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   output logic [BYTE_W-1:0] tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic              sw_rst,
   output logic [LANES-1:0]  lane_en,
   output logic              edge_fall
);
   localparam logic [LANES-1:0] DDR_MASK = LANES'(2'b11);

   generate
      if (BYTE_W != 8) begin : g_bad_byte
         $error("byte_pair_regctl: BYTE_W must be 8");
      end
      if (LANES < 2 || LANES > BYTE_W) begin : g_bad_lanes
         $error("byte_pair_regctl: LANES must lie in 2..BYTE_W");
      end
      if (TIMEOUT_CYC < 0) begin : g_bad_tmo
         $error("byte_pair_regctl: TIMEOUT_CYC must not be negative");
      end
   endgenerate

   logic              byte_fire, wr_en, rd_en, in_data, edge_sel;
   logic [BYTE_W-1:0] cur_addr, rdata;

   assign rx_ready  = !tx_valid;
   assign byte_fire = rx_valid && rx_ready;
   assign edge_fall = edge_sel && (lane_en != DDR_MASK);

   pair_fsm #(.BYTE_W(BYTE_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .byte_fire(byte_fire), .byte_in(rx_data),
      .wr_en(wr_en), .rd_en(rd_en), .addr_q(cur_addr), .in_data(in_data)
   );

   reg_bank #(.BYTE_W(BYTE_W), .LANES(LANES)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(cur_addr[BYTE_W-2:0]),
      .wdata(rx_data), .rdata(rdata), .sw_rst(sw_rst), .lane_en(lane_en),
      .edge_sel(edge_sel)
   );

   resp_buf #(.BYTE_W(BYTE_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .load(rd_en), .load_data(rdata),
      .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
   );
endmodule

// File: rtl/byte_pair_regctl_chk.sv
module byte_pair_regctl_chk #(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [BYTE_W-1:0] rx_data,
   input logic              rx_valid,
   input logic              rx_ready,
   input logic [BYTE_W-1:0] tx_data,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              sw_rst,
   input logic [LANES-1:0]  lane_en,
   input logic              edge_fall,
   input logic              in_data,
   input logic [BYTE_W-1:0] cur_addr
);
   logic data_fire, hit0, rd_fire;
   assign data_fire = in_data && rx_valid && rx_ready;
   assign hit0      = data_fire && (cur_addr == '0);
   assign rd_fire   = data_fire && cur_addr[BYTE_W-1];

   AST_SWRST_ON:   assert property (@(posedge clk) disable iff (!rst_n)
      hit0 && (rx_data == '1) |=> sw_rst);                                  // R2
   AST_SWRST_OFF:  assert property (@(posedge clk) disable iff (!rst_n)
      hit0 && (rx_data == '0) |=> !sw_rst);                                 // R2
   AST_SWRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !hit0 |=> $stable(sw_rst));                                           // R2
   AST_TX_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));              // R5
   AST_READ_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> tx_valid);                                                // R5
   AST_READ_NOWR:  assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> $stable(lane_en) && $stable(sw_rst));                     // R5
   AST_RX_BLOCK:   assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !rx_ready);                                              // R6
   AST_DDR_EDGE:   assert property (@(posedge clk) disable iff (!rst_n)
      lane_en == LANES'(2'b11) |-> !edge_fall);                             // R4
endmodule

bind byte_pair_regctl byte_pair_regctl_chk #(.BYTE_W(BYTE_W), .LANES(LANES)) u_chk (
   .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
   .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
   .tx_ready(tx_ready), .sw_rst(sw_rst), .lane_en(lane_en),
   .edge_fall(edge_fall), .in_data(in_data), .cur_addr(cur_addr)
);

// File: tb/test_byte_pair_regctl.sv
module test_byte_pair_regctl;
   localparam int TO = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_valid = 1'b0;
   logic       tx_ready = 1'b0;
   logic       rx_ready, tx_valid, sw_rst, edge_fall;
   logic [7:0] tx_data;
   logic [3:0] lane_en;

   int vectors = 0;
   int fails = 0;

   always #4 clk = ~clk;

   byte_pair_regctl #(.BYTE_W(8), .LANES(4), .TIMEOUT_CYC(TO)) i_byte_pair_regctl (
      .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .sw_rst(sw_rst), .lane_en(lane_en), .edge_fall(edge_fall)
   );

   // behavioural reference model
   bit       m_wait, m_txv, m_sw, m_edge;
   bit [7:0] m_addr, m_txd;
   bit [3:0] m_mask;
   int       m_tmr;

   function automatic bit [7:0] m_read(bit [6:0] a);
      if (a == 7'h00) return m_sw ? 8'hFF : 8'h00;
      if (a == 7'h02) return {4'h0, m_mask};
      if (a == 7'h13) return {7'h0, m_edge};
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wait = 0; m_txv = 0; m_sw = 0; m_edge = 0;
         m_addr = 0; m_txd = 0; m_mask = 0; m_tmr = 0;
      end else begin
         bit acc;
         acc = rx_valid && !m_txv;
         if (m_txv && tx_ready) m_txv = 0;
         if (!m_wait) begin
            if (acc) begin m_addr = rx_data; m_wait = 1; m_tmr = 0; end
         end else if (acc) begin
            m_wait = 0;
            if (m_addr[7]) begin
               m_txv = 1; m_txd = m_read(m_addr[6:0]);
            end else if (m_addr == 8'h00) begin
               if (rx_data == 8'hFF) m_sw = 1;
               else if (rx_data == 8'h00) m_sw = 0;
            end else if (m_addr == 8'h02) m_mask = rx_data[3:0];
            else if (m_addr == 8'h13) m_edge = rx_data[0];
         end else if (m_tmr == TO - 1) m_wait = 0;
         else m_tmr++;
      end
   end

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R2 sw_rst", sw_rst, m_sw);
      chk("R3 lane_en", lane_en, m_mask);
      chk("R4 edge_fall", edge_fall, m_edge && (m_mask != 4'b0011));
      chk("R5 tx_valid", tx_valid, m_txv);
      if (m_txv) chk("R5 tx_data", tx_data, m_txd);
      chk("R6 rx_ready", rx_ready, !m_txv);
   endtask

   // drive inputs now (just after a falling edge), pass one rising edge, compare
   task automatic drive(bit v, bit [7:0] d, bit r);
      rx_valid = v; rx_data = d; tx_ready = r;
      @(negedge clk);
      compare();
   endtask

   task automatic wr(bit [7:0] a, bit [7:0] d);
      drive(1, a, 0); drive(1, d, 0); drive(0, 8'h00, 0);
   endtask

   task automatic rd(bit [7:0] a, output bit [7:0] val);
      drive(1, a | 8'h80, 0); drive(1, 8'h5A, 0);
      val = tx_data;
      drive(0, 8'h00, 1);
      drive(0, 8'h00, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin : stim
      bit [7:0] v;
      bit [15:0] lf;
      repeat (3) @(negedge clk);
      chk("R10 sw_rst", sw_rst, 0);
      chk("R10 lane_en", lane_en, 0);
      chk("R10 tx_valid", tx_valid, 0);
      chk("R10 rx_ready", rx_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R3: write lane mask 0x03
      wr(8'h02, 8'h03);
      chk("R1 R3 mask 0x03", lane_en, 4'h3);
      // R4: edge bit ignored in two-lane DDR mode
      wr(8'h13, 8'h01);
      chk("R4 DDR forces rising", edge_fall, 0);
      wr(8'h02, 8'hF4);
      chk("R3 upper bits dropped", lane_en, 4'h4);
      chk("R4 falling edge honoured", edge_fall, 1);

      // R5 R6: read with held reply, rx blocked meanwhile
      drive(1, 8'h82, 0); drive(1, 8'h13, 0);
      chk("R5 reply valid", tx_valid, 1);
      chk("R5 reply data", tx_data, 8'h04);
      drive(1, 8'h13, 0); drive(1, 8'h00, 0);
      chk("R6 rx blocked", rx_ready, 0);
      chk("R5 reply held", tx_data, 8'h04);
      drive(0, 8'h00, 1);
      chk("R5 reply taken", tx_valid, 0);
      rd(8'h13, v);
      chk("R4 edge readback", v, 8'h01);

      // R2 R8: software reset
      wr(8'h00, 8'hFF);
      chk("R2 sw_rst set", sw_rst, 1);
      wr(8'h00, 8'h12);
      chk("R2 other value holds", sw_rst, 1);
      rd(8'h00, v);
      chk("R2 readback set", v, 8'hFF);
      chk("R8 mask kept", lane_en, 4'h4);
      wr(8'h00, 8'h00);
      chk("R2 sw_rst released", sw_rst, 0);

      // R9: unmapped
      wr(8'h40, 8'hAA);
      rd(8'h40, v);
      chk("R9 unmapped read", v, 8'h00);
      chk("R9 mask kept", lane_en, 4'h4);

      // R7: lone byte times out, next byte is an address again
      drive(1, 8'h02, 0);
      repeat (TO + 1) drive(0, 8'h00, 0);
      wr(8'h13, 8'h00);
      chk("R7 resynced edge", edge_fall, 0);
      chk("R7 mask untouched", lane_en, 4'h4);
      // R1 R7: data inside window still pairs
      drive(1, 8'h02, 0);
      repeat (TO - 2) drive(0, 8'h00, 0);
      drive(1, 8'h08, 0); drive(0, 8'h00, 0);
      chk("R7 late data paired", lane_en, 4'h8);

      // mixed traffic against the model
      lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         drive(lf[0] | lf[5], (lf[3:2] == 2'b00) ? 8'hFF :
               {lf[15], 2'b00, lf[12], 2'b00, lf[9:8]} | {3'b0, lf[11], 4'b0}, lf[7]);
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule